// File: doc/BRIEF.md
# Oversampling Rate Generator with Fractional Divider

This block derives the 16x oversampling strobe of an asynchronous serial port from the system clock. A small write-only register bus sets it up. The setup is a control word, a 13-bit reload value and a 9-bit fractional step. One bit in the control word selects the rate path, and the generator then produces a one-clock `tick` at the selected rate.

Two rate paths feed a shared 13-bit down-counter. On the integer path, a divide-by-2 or divide-by-3 prescaler gives the counter one enable every P clocks. On the fractional path, a 9-bit phase accumulator adds the step value on every clock and gives one enable on each carry, which is F enables out of every 512 clocks. The reload counter starts from the reload value and counts enables down. It fires `tick` on the enable that finds it at zero, and reloads at the same time.

A two-state controller sequences the generator. The states are `ST_IDLE` and `ST_COUNT`, and there are three transitions:
- **arm** (`ST_IDLE` to `ST_COUNT`): taken when the run bit is set; it loads the reload value.
- **step** (`ST_COUNT` to `ST_COUNT`): taken on each enable; it decrements the counter, or ticks and reloads.
- **halt** (`ST_COUNT` to `ST_IDLE`): taken when the run bit is cleared.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset the run bit is 0 and `tick` stays low.
- R2: Register addresses are 0 for control, 1 for reload (`wr_data[12:0]`) and 2 for the fractional step (`wr_data[8:0]`). In the control word, bit 0 is run, bit 1 selects the fractional path and bit 2 selects the prescale factor. A write takes effect on the clock edge where `wr_en` is high.
- R3: On the integer path with prescale select 0 (P=2), the k-th tick appears exactly k·P·(reload+1) clock cycles after the first cycle in which run reads 1.
- R4: Prescale select 1 gives P=3, with the same timing rule as R3.
- R5: On the fractional path with step F, the k-th tick appears exactly ceil(k·(reload+1)·512/F) cycles after the first cycle in which run reads 1.
- R6: A fractional step of 0 behaves as F=512, so the fractional path passes every clock.
- R7: A reload write made while run is 1 is ignored. The stored reload value, and therefore the tick period, stays unchanged, also across a later restart.
- R8: Each 0-to-1 transition of run loads the counter from the reload register, so a reload value written while stopped is used from the next start.
- R9: While run is 0, `tick` is low. It is low from the first cycle after the clearing write.
- R10: The reload value boundaries 0 and 8191 follow the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 13 | Write data |
| tick | output | 1 | One-cycle oversampling strobe |

## Verification
The assertions take for granted that the path-select bit is not switched during a run in a way that depends on the integer prescaler's phase. They also take for granted that the fractional step register is rewritten only while run is 0, because the accumulator rule assumes a constant step. The stimulus always stops the generator before it reconfigures the path, the step or the reload value. The only writes made during a run are reload writes aimed at the lockout.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

    // Register select codes on the write bus
    localparam int REG_CTRL   = 0;
    localparam int REG_RELOAD = 1;
    localparam int REG_STEP   = 2;

    // Control word bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_FRAC = 1;
    localparam int CTRL_PSEL = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/bfg_regs.sv
module bfg_regs
    import bfg_pkg::*;
#(
    parameter int RELOAD_W = 13,
    parameter int FRAC_W   = 9,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [RELOAD_W-1:0] wr_data,
    output logic                run_o,
    output logic                frac_o,
    output logic                psel_o,
    output logic [RELOAD_W-1:0] reload_o,
    output logic [FRAC_W-1:0]   step_o
);

    logic                run_q;
    logic                frac_q;
    logic                psel_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [FRAC_W-1:0]   step_q;

    logic hit_ctrl, hit_reload, hit_step;

    always_comb begin
        hit_ctrl   = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
        hit_reload = wr_en && (wr_addr == ADDR_W'(REG_RELOAD));
        hit_step   = wr_en && (wr_addr == ADDR_W'(REG_STEP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            frac_q <= 1'b0;
            psel_q <= 1'b0;
        end else if (hit_ctrl) begin
            run_q  <= wr_data[CTRL_RUN];
            frac_q <= wr_data[CTRL_FRAC];
            psel_q <= wr_data[CTRL_PSEL];
        end
    end

    // Reload is locked while the generator runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (hit_reload && !run_q) begin
            reload_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (hit_step) begin
            step_q <= wr_data[FRAC_W-1:0];
        end
    end

    assign run_o    = run_q;
    assign frac_o   = frac_q;
    assign psel_o   = psel_q;
    assign reload_o = reload_q;
    assign step_o   = step_q;

endmodule

// File: rtl/bfg_prescale.sv
module bfg_prescale #(
    parameter int FRAC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frac_en,
    input  logic              psel,
    input  logic [FRAC_W-1:0] step,
    output logic              pulse_o
);

    localparam int SUM_W = FRAC_W + 1;

    // Integer path: divide by 2 or 3
    logic [1:0] div_q;
    logic [1:0] div_last;
    logic       int_on;
    logic       int_pulse;

    always_comb begin
        div_last  = psel ? 2'd2 : 2'd1;
        int_on    = enable && !frac_en;
        int_pulse = int_on && (div_q == div_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!int_on || (div_q == div_last)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 2'd1;
        end
    end

    // Fractional path: phase accumulator, a step of 0 means full scale
    logic [FRAC_W-1:0] acc_q;
    logic [SUM_W-1:0]  step_eff;
    logic [SUM_W-1:0]  sum;
    logic              frac_on;
    logic              frac_pulse;

    always_comb begin
        step_eff   = (step == '0) ? SUM_W'(1) << FRAC_W : {1'b0, step};
        sum        = {1'b0, acc_q} + step_eff;
        frac_on    = enable && frac_en;
        frac_pulse = frac_on && sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (frac_on) begin
            acc_q <= sum[FRAC_W-1:0];
        end else begin
            acc_q <= '0;
        end
    end

    assign pulse_o = int_pulse || frac_pulse;

endmodule

// File: rtl/bfg_reload_fsm.sv
module bfg_reload_fsm
    import bfg_pkg::*;
#(
    parameter int RELOAD_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                pulse,
    input  logic [RELOAD_W-1:0] reload,
    output logic                counting_o,
    output logic                tick_o
);

    run_state_e          state_q, state_d;
    logic [RELOAD_W-1:0] cnt_q, cnt_d;

    // Next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_COUNT;   // arm
                    cnt_d   = reload;
                end
            end
            ST_COUNT: begin
                if (!run) begin
                    state_d = ST_IDLE;    // halt
                end else if (pulse) begin // step
                    cnt_d = (cnt_q == '0) ? reload : cnt_q - RELOAD_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        counting_o = (state_q == ST_COUNT);
        tick_o     = counting_o && run && pulse && (cnt_q == '0);
    end

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int RELOAD_W = 13,
    parameter int FRAC_W   = 9,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [RELOAD_W-1:0] wr_data,
    output logic                tick
);

    logic                run_q;
    logic                frac_q;
    logic                psel_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [FRAC_W-1:0]   fdv_q;
    logic                pre_en;
    logic                pre_pulse;
    logic                counting;

    bfg_regs #(
        .RELOAD_W (RELOAD_W),
        .FRAC_W   (FRAC_W),
        .ADDR_W   (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run_o    (run_q),
        .frac_o   (frac_q),
        .psel_o   (psel_q),
        .reload_o (reload_q),
        .step_o   (fdv_q)
    );

    assign pre_en = run_q && counting;

    bfg_prescale #(
        .FRAC_W (FRAC_W)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (pre_en),
        .frac_en (frac_q),
        .psel    (psel_q),
        .step    (fdv_q),
        .pulse_o (pre_pulse)
    );

    bfg_reload_fsm #(
        .RELOAD_W (RELOAD_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .pulse      (pre_pulse),
        .reload     (reload_q),
        .counting_o (counting),
        .tick_o     (tick)
    );

endmodule

// File: rtl/bfg_checker.sv
module bfg_checker #(
    parameter int RELOAD_W = 13,
    parameter int FRAC_W   = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_q,
    input logic                frac_q,
    input logic [RELOAD_W-1:0] reload_q,
    input logic [FRAC_W-1:0]   fdv_q,
    input logic                pre_en,
    input logic                pre_pulse,
    input logic                counting,
    input logic                tick
);

    assert_reload_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(reload_q));

    assert_arm_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |=> counting);

    assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !counting);

    assert_int_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_pulse && !frac_q) |=> !(pre_pulse && !frac_q));

    assert_zero_step_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && frac_q && (fdv_q == '0)) |-> pre_pulse);

    assert_tick_when_counting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (counting && run_q));

endmodule

bind baud_frac_gen bfg_checker #(
    .RELOAD_W (RELOAD_W),
    .FRAC_W   (FRAC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_q     (run_q),
    .frac_q    (frac_q),
    .reload_q  (reload_q),
    .fdv_q     (fdv_q),
    .pre_en    (pre_en),
    .pre_pulse (pre_pulse),
    .counting  (counting),
    .tick      (tick)
);

// File: tb/baud_frac_gen_tb_top.sv
module baud_frac_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        tick;

    always #4 clk = ~clk;   // 125 MHz

    baud_frac_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick)
    );

    int    checks = 0;
    int    fails  = 0;
    int    ncyc   = 0;
    int    start  = 0;
    bit    arm_req = 0;
    bit    allow_extra = 0;
    bit    quiet = 0;
    string quiet_tag = "";
    int    exp_q[$];
    string tag_q[$];
    logic [12:0] ctrl_mode = '0;

    // Monitor: pops expected tick offsets and compares them
    always @(negedge clk) begin
        ncyc++;
        if (arm_req) begin
            start   = ncyc;
            arm_req = 0;
        end
        if (tick === 1'b1) begin
            if (quiet) begin
                fails++;
                $display("FAIL %s: tick actual=1 expected=0 at cycle %0d", quiet_tag, ncyc);
            end else if (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (ncyc - start != e) begin
                    fails++;
                    $display("FAIL %s: tick offset actual=%0d expected=%0d", t, ncyc - start, e);
                end
            end else if (!allow_extra) begin
                fails++;
                $display("FAIL R9: unexpected tick actual=1 expected=0 at cycle %0d", ncyc);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic wr(input logic [1:0] a, input logic [12:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    // Driver: configure while stopped (R2 encoding)
    task automatic cfg(input bit frac, input bit psel, input int reload, input int step);
        ctrl_mode = {10'd0, psel, frac, 1'b0};
        wr(2'd0, ctrl_mode);
        wr(2'd1, 13'(reload));
        wr(2'd2, 13'(step));
    endtask

    // Driver: push expected tick offsets into the scoreboard
    task automatic expect_ticks(input int n, input bit frac, input bit psel,
                                input int reload, input int step, input string tag);
        for (int k = 1; k <= n; k++) begin
            longint off;
            if (frac) begin
                longint f;
                f   = (step == 0) ? 512 : step;
                off = (longint'(k) * (reload + 1) * 512 + f - 1) / f;
            end else begin
                off = longint'(k) * (psel ? 3 : 2) * (reload + 1);
            end
            exp_q.push_back(int'(off));
            tag_q.push_back(tag);
        end
    endtask

    task automatic go();
        wr(2'd0, ctrl_mode | 13'd1);
        arm_req = 1;
    endtask

    task automatic drain(input string tag);
        int w = 0;
        while (exp_q.size() > 0 && w < 60000) begin
            @(posedge clk);
            w++;
        end
        if (exp_q.size() > 0) begin
            fails++;
            $display("FAIL %s: pending ticks actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
        allow_extra = 1;
    endtask

    task automatic stop();
        wr(2'd0, ctrl_mode);
        allow_extra = 0;
    endtask

    task automatic quiet_window(input int n, input string tag);
        quiet_tag = tag;
        quiet = 1;
        repeat (n) @(posedge clk);
        #2 quiet = 0;
        checks++;
    endtask

    task automatic phase(input int n, input bit frac, input bit psel,
                         input int reload, input int step, input string tag);
        cfg(frac, psel, reload, step);
        expect_ticks(n, frac, psel, reload, step, tag);
        go();
        drain(tag);
        stop();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (tick !== 1'b0) begin
            fails++;
            $display("FAIL R1: tick after reset actual=%b expected=0", tick);
        end
        quiet_window(10, "R1");

        // Configured but not running: no ticks
        cfg(1'b0, 1'b0, 0, 0);
        quiet_window(40, "R9");

        phase(5, 1'b0, 1'b0, 4, 0, "R3");
        phase(5, 1'b0, 1'b1, 2, 0, "R4");
        phase(4, 1'b0, 1'b1, 0, 0, "R4");
        phase(6, 1'b1, 1'b0, 1, 100, "R5");
        phase(8, 1'b1, 1'b0, 0, 511, "R5");
        phase(4, 1'b1, 1'b0, 5, 37, "R5");
        phase(5, 1'b1, 1'b0, 3, 0, "R6");
        phase(6, 1'b0, 1'b0, 0, 0, "R10");

        // Reload lockout (R7) and restart loading (R8)
        cfg(1'b0, 1'b0, 2, 0);
        expect_ticks(4, 1'b0, 1'b0, 2, 0, "R7");
        go();
        wr(2'd1, 13'd7);          // ignored while running
        drain("R7");
        stop();
        expect_ticks(3, 1'b0, 1'b0, 2, 0, "R7");
        go();
        drain("R7");
        stop();
        wr(2'd1, 13'd7);
        expect_ticks(3, 1'b0, 1'b0, 7, 0, "R8");
        go();
        drain("R8");
        stop();
        quiet_window(30, "R9");

        phase(1, 1'b0, 1'b0, 8191, 0, "R10");
        quiet_window(20, "R9");

        summary();
        $finish;
    end

endmodule